// File: doc/BRIEF.md
# Next-PC Generation Unit

This block holds the program counter of a simple processor and picks the address of the next instruction fetch on every rising clock edge. Four address sources feed the choice. The first is the sequential address, the current PC plus four. The second is a PC-relative branch target built from a signed 16-bit word offset. The third is a 32-bit register value for an indirect jump. The fourth is a direct target formed from a 26-bit word index and the upper bits of the sequential address.

The decoder supplies the offset, the direct target field and the two jump selects. Logic outside the block compares the registers and supplies the branch condition as one taken bit. The registered PC drives the instruction memory address directly. There is no stall, so the PC takes a new value on every clock.

Top module: `pc_gen_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0x00000000. The reset acts asynchronously and holds through any clock edges that occur while it is asserted.
- R2: With `br_taken_i`, `jr_i` and `jump_i` all low, each rising edge loads `pc_o + 4`.
- R3: With `br_taken_i` high and both jump selects low, each rising edge loads `pc_o + 4 + 4*ofs`, where ofs is the value of `br_ofs_i`.
- R4: `br_ofs_i` is two's complement, with bit 15 as the sign bit, so offsets from -32768 to 32767 words reach both backward and forward.
- R5: With `jr_i` high and `jump_i` low, the edge loads `rs_val_i` unchanged, including its two low bits, whatever the value of `br_taken_i`.
- R6: With `jump_i` high, the edge loads {bits 31..28 of `pc_o + 4`, `jmp_tgt_i`, 2'b00}, whatever the values of `jr_i` and `br_taken_i`.
- R7: All PC arithmetic is modulo 2^32. For example, 0xFFFFFFFC steps to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the PC updates on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_taken_i | input | 1 | Branch condition is true |
| jr_i | input | 1 | Select the register-indirect jump |
| jump_i | input | 1 | Select the direct jump |
| br_ofs_i | input | 16 | Signed branch offset, in words |
| jmp_tgt_i | input | 26 | Direct jump word index |
| rs_val_i | input | 32 | Register value used as the indirect target |
| pc_o | output | 32 | Registered program counter |

## Verification
Every internal fault shows on `pc_o` at the first rising edge after the faulty source is selected. The cause can be a wrong sign extension, a missing word shift, a swapped priority, or upper bits taken from the old PC instead of PC+4. The bench chains all 65536 branch offsets back to back, so a single wrong addend corrupts every later PC and is caught at once. It also drives every combination of the three selects, which exposes any inversion of the priority order on the next edge.

// File: rtl/pcgen_pkg.sv
package pcgen_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_BR  = 2'd1,
    NPC_REG = 2'd2,
    NPC_DIR = 2'd3
  } npc_src_e;
endpackage

// File: rtl/npc_linear.sv
// Sequential and PC-relative candidates
module npc_linear #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int STEP  = 4
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  br_o
);
  localparam int SH = $clog2(STEP);

  logic [XLEN-1:0] ofs_ext;

  assign ofs_ext = XLEN'($signed(ofs_i)) << SH;
  assign seq_o   = pc_i + XLEN'(STEP);
  assign br_o    = seq_o + ofs_ext;
endmodule

// File: rtl/npc_abs_target.sv
// Direct target: upper bits of PC+step, word index, zero alignment bits
module npc_abs_target #(
  parameter int XLEN  = 32,
  parameter int TGT_W = 26,
  parameter int STEP  = 4
) (
  input  logic [XLEN-1:0]  seq_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [XLEN-1:0]  tgt_o
);
  localparam int SH   = $clog2(STEP);
  localparam int HI_W = XLEN - TGT_W - SH;

  generate
    if (HI_W > 0) begin : g_region
      assign tgt_o = {seq_i[XLEN-1 -: HI_W], tgt_i, {SH{1'b0}}};
    end else begin : g_full
      assign tgt_o = XLEN'({tgt_i, {SH{1'b0}}});
    end
  endgenerate
endmodule

// File: rtl/npc_priority.sv
// Priority chain: direct jump > register jump > branch > sequential
module npc_priority
  import pcgen_pkg::*;
(
  input  logic     br_taken_i,
  input  logic     jr_i,
  input  logic     jump_i,
  output npc_src_e src_o
);
  always_comb begin
    if (jump_i)          src_o = NPC_DIR;
    else if (jr_i)       src_o = NPC_REG;
    else if (br_taken_i) src_o = NPC_BR;
    else                 src_o = NPC_SEQ;
  end
endmodule

// File: rtl/pc_gen_unit.sv
module pc_gen_unit
  import pcgen_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int TGT_W = 26,
  parameter int STEP  = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             br_taken_i,
  input  logic             jr_i,
  input  logic             jump_i,
  input  logic [OFS_W-1:0] br_ofs_i,
  input  logic [TGT_W-1:0] jmp_tgt_i,
  input  logic [XLEN-1:0]  rs_val_i,
  output logic [XLEN-1:0]  pc_o
);
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] seq_addr, br_addr, dir_addr;
  npc_src_e        src;

  npc_linear #(.XLEN(XLEN), .OFS_W(OFS_W), .STEP(STEP)) i_linear (
    .pc_i  (pc_q),
    .ofs_i (br_ofs_i),
    .seq_o (seq_addr),
    .br_o  (br_addr)
  );

  npc_abs_target #(.XLEN(XLEN), .TGT_W(TGT_W), .STEP(STEP)) i_abs (
    .seq_i (seq_addr),
    .tgt_i (jmp_tgt_i),
    .tgt_o (dir_addr)
  );

  npc_priority i_prio (
    .br_taken_i (br_taken_i),
    .jr_i       (jr_i),
    .jump_i     (jump_i),
    .src_o      (src)
  );

  always_comb begin
    unique case (src)
      NPC_BR:  pc_d = br_addr;
      NPC_REG: pc_d = rs_val_i;
      NPC_DIR: pc_d = dir_addr;
      default: pc_d = seq_addr;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pc_gen_unit_chk.sv
module pc_gen_unit_chk #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int TGT_W = 26,
  parameter int STEP  = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             br_taken_i,
  input logic             jr_i,
  input logic             jump_i,
  input logic [OFS_W-1:0] br_ofs_i,
  input logic [TGT_W-1:0] jmp_tgt_i,
  input logic [XLEN-1:0]  rs_val_i,
  input logic [XLEN-1:0]  pc_o
);
  localparam int SH   = $clog2(STEP);
  localparam int HI_W = XLEN - TGT_W - SH;

  logic [XLEN-1:0] step_c;
  assign step_c = XLEN'(STEP);

  // R1
  rst_value_chk: assert property (@(posedge clk_i)
    !rst_ni |=> pc_o == RESET_PC);

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_taken_i && !jr_i && !jump_i) |=> pc_o == $past(pc_o) + step_c);

  // R3
  br_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_taken_i && !jr_i && !jump_i) |=>
      pc_o == $past(pc_o) + step_c + (XLEN'($signed($past(br_ofs_i))) << SH));

  // R5
  jr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jr_i && !jump_i) |=> pc_o == $past(rs_val_i));

  // R6
  jump_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i |=> pc_o[XLEN-HI_W-1:SH] == $past(jmp_tgt_i) && pc_o[SH-1:0] == '0);
endmodule

bind pc_gen_unit pc_gen_unit_chk #(
  .XLEN(XLEN), .OFS_W(OFS_W), .TGT_W(TGT_W), .STEP(STEP), .RESET_PC(RESET_PC)
) i_pc_gen_unit_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .br_taken_i (br_taken_i),
  .jr_i       (jr_i),
  .jump_i     (jump_i),
  .br_ofs_i   (br_ofs_i),
  .jmp_tgt_i  (jmp_tgt_i),
  .rs_val_i   (rs_val_i),
  .pc_o       (pc_o)
);

// File: tb/test_pc_gen_unit.sv
module test_pc_gen_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        br_taken_i = 1'b0;
  logic        jr_i = 1'b0;
  logic        jump_i = 1'b0;
  logic [15:0] br_ofs_i = '0;
  logic [25:0] jmp_tgt_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] pc_o;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] model;

  pc_gen_unit i_pc_gen_unit (
    .clk_i, .rst_ni, .br_taken_i, .jr_i, .jump_i,
    .br_ofs_i, .jmp_tgt_i, .rs_val_i, .pc_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] exp_next(input logic [31:0] pc, input logic br,
      input logic jr, input logic j, input logic [15:0] o, input logic [25:0] t,
      input logic [31:0] r);
    logic [31:0] p4;
    p4 = pc + 32'd4;
    if (j)  return {p4[31:28], t, 2'b00};
    if (jr) return r;
    if (br) return p4 + {{14{o[15]}}, o, 2'b00};
    return p4;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    n_run++;
    if (pc_o !== exp) begin
      n_fail++;
      $display("FAIL %s: pc_o=%h expected=%h", req, pc_o, exp);
    end
  endtask

  // Drive at negedge, clock once, sample at the following negedge
  task automatic step(input string req, input logic br, input logic jr, input logic j,
      input logic [15:0] o, input logic [25:0] t, input logic [31:0] r);
    br_taken_i = br; jr_i = jr; jump_i = j;
    br_ofs_i = o; jmp_tgt_i = t; rs_val_i = r;
    model = exp_next(model, br, jr, j, o, t, r);
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, model);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: pc_o=%h expected=finish", pc_o);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: held through clock edges
    repeat (3) @(negedge clk_i);
    check("R1", 32'h0);
    rst_ni = 1'b1;
    model = 32'h0;

    // R2: sequential stepping
    for (int i = 0; i < 64; i++) step("R2", 1'b0, 1'b0, 1'b0, 16'hFFFF, 26'h3FFFFFF, 32'hDEAD_BEEF);

    // R3 / R4: every branch offset, chained
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] o;
      o = 16'(i);
      step(o[15] ? "R4" : "R3", 1'b1, 1'b0, 1'b0, o, 26'(i * 7), 32'(i * 13));
    end
    step("R4", 1'b1, 1'b0, 1'b0, 16'h8000, '0, '0);
    step("R3", 1'b1, 1'b0, 1'b0, 16'h7FFF, '0, '0);

    // R5 / R6: all select combinations against varied data
    for (int k = 0; k < 64; k++) begin
      for (int c = 0; c < 8; c++) begin
        logic [31:0] r;
        r = 32'h9E37_79B9 * (k + 1) + 32'(c);
        step(c[2] ? "R6" : (c[1] ? "R5" : (c[0] ? "R3" : "R2")),
             c[0], c[1], c[2], 16'(k * 977), 26'(k * 40503 + c), r);
      end
    end

    // R6: upper bits come from PC+4, crossing a region boundary
    step("R5", 1'b0, 1'b1, 1'b0, '0, '0, 32'hEFFF_FFFC);
    step("R6", 1'b1, 1'b1, 1'b1, 16'h1234, 26'h2AA_AAAA, 32'h1111_1111);
    for (int i = 0; i < 2048; i++)
      step("R6", i[0], i[1], 1'b1, 16'(i), 26'(i * 32771), 32'(i * 3));

    // R5: unaligned register value taken verbatim
    step("R5", 1'b1, 1'b1, 1'b0, 16'h0010, '0, 32'h1234_5677);

    // R7: wrap of sequential and branch arithmetic
    step("R5", 1'b0, 1'b1, 1'b0, '0, '0, 32'hFFFF_FFFC);
    step("R7", 1'b0, 1'b0, 1'b0, '0, '0, '0);
    step("R5", 1'b0, 1'b1, 1'b0, '0, '0, 32'hFFFF_FFF8);
    step("R7", 1'b1, 1'b0, 1'b0, 16'h0002, '0, '0);
    step("R7", 1'b1, 1'b0, 1'b0, 16'hFFFC, '0, '0);

    // R1: asynchronous assertion mid-cycle
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    check("R1", 32'h0);
    @(negedge clk_i);
    check("R1", 32'h0);
    rst_ni = 1'b1;
    model = 32'h0;
    step("R2", 1'b0, 1'b0, 1'b0, '0, '0, '0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule